// File: doc/BRIEF.md
# External Interrupt Pin Conditioning Unit

This block sits between the package pins that carry external interrupt requests and the core-side interrupt controller. It takes sixteen active-low general interrupt pins, one active-low high-priority pin and two active-low non-maskable pins. Every pin is brought into the core clock domain through a flop chain before any logic looks at it.

For the general pins and the high-priority pin the block works on levels. A pin held low raises its pending bit for as long as it stays low, provided its enable bit is set and its pin group is in interrupt function. The sixteen pins fall into three groups. Pins 0 to 3 give up their input role when the chip is a bus endpoint, because they then drive the four bus interrupt lines, or when they are given to general-purpose I/O. Pins 4 to 7 serve as interrupts unless they are given to general-purpose I/O. Pins 8 to 15 serve as interrupts only while they are set up as general-purpose inputs.

The two non-maskable pins bypass all masking. A falling edge on either one gives a single-cycle abort pulse to its own core. The block also drives output enables for the four open-drain bus interrupt lines from internal request sources while endpoint mode is on.

Top module: `xint_pin_cond`

## Requirements
- R1: With the default of two synchronizer stages, a level change on an enabled, qualified general pin shows on `irq_pending` at the third rising clock edge after the change, and not before.
- R2: A pending bit stays 1 for as long as its pin is held low and returns to 0 with the same latency once the pin goes high.
- R3: A general pin whose `irq_enable` bit is 0 never sets its pending bit, whatever its level.
- R4: `hp_req` follows a low level on `hp_irq_n` with the R1 latency, and is 0 whenever `hp_enable` was 0 at the previous edge.
- R5: Pins 0 to 3 never set pending bits while `endpoint_mode` is 1 or `lo_gpio_sel` is 1.
- R6: Pins 4 to 7 never set pending bits while `mid_gpio_sel` is 1.
- R7: Pins 8 to 15 set pending bits only while `hi_gpio_in` is 1.
- R8: A falling edge on `nmi_n[i]` gives exactly one cycle of 1 on `nmi_abort[i]` at the third rising edge after the edge. No enable or mode input affects it. A pin held low or a rising edge gives no pulse, and each pin drives only its own output bit.
- R9: `bus_irq_oe[i]` is 1 one edge after `endpoint_mode` and `bus_irq_src[i]` are both 1, and is 0 otherwise. A 1 means the line is pulled low.
- R10: While `rst_n` is 0, every output is 0. Leaving reset with the non-maskable pins high produces no abort pulse.
- R11: A change to `irq_enable`, `hp_enable`, `endpoint_mode` or a group select changes the pending outputs at the next rising edge when the pins are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 16 | General interrupt pins, active low, asynchronous |
| hp_irq_n | input | 1 | High-priority interrupt pin, active low |
| nmi_n | input | 2 | Non-maskable pins, active low, falling-edge; bit i serves core i |
| irq_enable | input | 16 | Per-pin enable, 1 = unmasked |
| hp_enable | input | 1 | Enable for the high-priority pin |
| lo_gpio_sel | input | 1 | 1 = pins 0..3 used as general-purpose I/O |
| mid_gpio_sel | input | 1 | 1 = pins 4..7 used as general-purpose I/O |
| hi_gpio_in | input | 1 | 1 = pins 8..15 set up as general-purpose inputs, which lets them interrupt |
| endpoint_mode | input | 1 | 1 = bus endpoint; pins 0..3 become interrupt outputs |
| bus_irq_src | input | 4 | Internal requests for bus interrupt lines A..D (bit 0 = A) |
| irq_pending | output | 16 | Qualified pending level requests |
| hp_req | output | 1 | Qualified high-priority request |
| nmi_abort | output | 2 | Single-cycle abort pulse per core |
| bus_irq_oe | output | 4 | Output enable of the open-drain bus interrupt lines |

## Verification
The bench builds the block with its default of two synchronizer stages. This fixes every pin-to-output path at three edges, so each check lands on a known cycle, and one early sample per path proves that a request does not arrive too soon. With that configuration the sixteen combinations of the four mode inputs are small enough to sweep completely. The bench drives each pin low on its own under two enable patterns in every combination, so every pin sees every group rule and both mask states.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    localparam int EXT_W   = 16;
    localparam int LO_TOP  = 3;
    localparam int MID_TOP = 7;
    localparam int NMI_W   = 2;
    localparam int BUS_W   = LO_TOP + 1;

    typedef enum logic [1:0] {
        GRP_LOW,
        GRP_MID,
        GRP_HIGH
    } pin_grp_e;

    typedef struct packed {
        logic [EXT_W-1:0] pend;
        logic             hp;
        logic [NMI_W-1:0] nmi_prev;
        logic [NMI_W-1:0] nmi_pulse;
        logic [BUS_W-1:0] bus_oe;
    } cond_state_t;

    localparam cond_state_t COND_RST = '{
        pend:      '0,
        hp:        1'b0,
        nmi_prev:  '1,
        nmi_pulse: '0,
        bus_oe:    '0
    };

    function automatic pin_grp_e grp_of(input int idx);
        if (idx <= LO_TOP)       return GRP_LOW;
        else if (idx <= MID_TOP) return GRP_MID;
        else                     return GRP_HIGH;
    endfunction

endpackage

// File: rtl/xpc_sync.sv
module xpc_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= {W{RST_VAL}};
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= stage_d[k];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xpc_qualify.sv
module xpc_qualify
    import xpc_pkg::*;
(
    input  logic [EXT_W-1:0] pin_sync_n,
    input  logic [EXT_W-1:0] enable,
    input  logic             lo_gpio_sel,
    input  logic             mid_gpio_sel,
    input  logic             hi_gpio_in,
    input  logic             endpoint_mode,
    output logic [EXT_W-1:0] req
);

    logic allow_low;
    logic allow_mid;
    logic allow_high;

    // Group rules: low pins lose input role in endpoint or GPIO use,
    // mid pins when given to GPIO, high pins need GPIO-input setup.
    assign allow_low  = ~endpoint_mode & ~lo_gpio_sel;
    assign allow_mid  = ~mid_gpio_sel;
    assign allow_high = hi_gpio_in;

    for (genvar i = 0; i < EXT_W; i++) begin : g_pin
        localparam pin_grp_e GRP = grp_of(i);
        logic allow;
        if (GRP == GRP_LOW) begin : g_low
            assign allow = allow_low;
        end else if (GRP == GRP_MID) begin : g_mid
            assign allow = allow_mid;
        end else begin : g_high
            assign allow = allow_high;
        end
        assign req[i] = ~pin_sync_n[i] & enable[i] & allow;
    end

endmodule

// File: rtl/xint_pin_cond.sv
module xint_pin_cond
    import xpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXT_W-1:0] ext_irq_n,
    input  logic             hp_irq_n,
    input  logic [NMI_W-1:0] nmi_n,
    input  logic [EXT_W-1:0] irq_enable,
    input  logic             hp_enable,
    input  logic             lo_gpio_sel,
    input  logic             mid_gpio_sel,
    input  logic             hi_gpio_in,
    input  logic             endpoint_mode,
    input  logic [BUS_W-1:0] bus_irq_src,
    output logic [EXT_W-1:0] irq_pending,
    output logic             hp_req,
    output logic [NMI_W-1:0] nmi_abort,
    output logic [BUS_W-1:0] bus_irq_oe
);

    localparam int ALL_W = EXT_W + 1 + NMI_W;

    logic [ALL_W-1:0] pins_raw;
    logic [ALL_W-1:0] pins_sync;
    logic [EXT_W-1:0] ext_sync_n;
    logic             hp_sync_n;
    logic [NMI_W-1:0] nmi_sync_n;
    logic [EXT_W-1:0] qual_req;

    cond_state_t st_d;
    cond_state_t st_q;

    assign pins_raw = {nmi_n, hp_irq_n, ext_irq_n};

    // One shared chain, preset to the idle-high pin level.
    xpc_sync #(
        .W       (ALL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_sync)
    );

    assign ext_sync_n = pins_sync[EXT_W-1:0];
    assign hp_sync_n  = pins_sync[EXT_W];
    assign nmi_sync_n = pins_sync[ALL_W-1:EXT_W+1];

    xpc_qualify qual_i (
        .pin_sync_n    (ext_sync_n),
        .enable        (irq_enable),
        .lo_gpio_sel   (lo_gpio_sel),
        .mid_gpio_sel  (mid_gpio_sel),
        .hi_gpio_in    (hi_gpio_in),
        .endpoint_mode (endpoint_mode),
        .req           (qual_req)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pend      = qual_req;
        st_d.hp        = ~hp_sync_n & hp_enable;
        st_d.nmi_prev  = nmi_sync_n;
        st_d.nmi_pulse = st_q.nmi_prev & ~nmi_sync_n;
        st_d.bus_oe    = {BUS_W{endpoint_mode}} & bus_irq_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= COND_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pending = st_q.pend;
    assign hp_req      = st_q.hp;
    assign nmi_abort   = st_q.nmi_pulse;
    assign bus_irq_oe  = st_q.bus_oe;

endmodule

// File: rtl/xint_pin_cond_chk.sv
module xint_pin_cond_chk
    import xpc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [EXT_W-1:0] irq_enable,
    input logic             hp_enable,
    input logic             lo_gpio_sel,
    input logic             mid_gpio_sel,
    input logic             hi_gpio_in,
    input logic             endpoint_mode,
    input logic [BUS_W-1:0] bus_irq_src,
    input logic [EXT_W-1:0] irq_pending,
    input logic             hp_req,
    input logic [NMI_W-1:0] nmi_abort,
    input logic [BUS_W-1:0] bus_irq_oe
);

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending & ~$past(irq_enable)) == '0);

    p_hp_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hp_req |-> $past(hp_enable));

    p_low_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending[LO_TOP:0] != '0) |-> !$past(endpoint_mode || lo_gpio_sel));

    p_mid_grp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending[MID_TOP:LO_TOP+1] != '0) |-> !$past(mid_gpio_sel));

    p_high_grp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending[EXT_W-1:MID_TOP+1] != '0) |-> $past(hi_gpio_in));

    p_nmi_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_abort != '0) |=> ((nmi_abort & $past(nmi_abort)) == '0));

    p_bus_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq_oe != '0) |-> $past(endpoint_mode));

    p_bus_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq_oe & ~$past(bus_irq_src)) == '0);

endmodule

bind xint_pin_cond xint_pin_cond_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_enable    (irq_enable),
    .hp_enable     (hp_enable),
    .lo_gpio_sel   (lo_gpio_sel),
    .mid_gpio_sel  (mid_gpio_sel),
    .hi_gpio_in    (hi_gpio_in),
    .endpoint_mode (endpoint_mode),
    .bus_irq_src   (bus_irq_src),
    .irq_pending   (irq_pending),
    .hp_req        (hp_req),
    .nmi_abort     (nmi_abort),
    .bus_irq_oe    (bus_irq_oe)
);

// File: tb/xint_pin_cond_tb_top.sv
module xint_pin_cond_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ext_irq_n;
    logic        hp_irq_n;
    logic [1:0]  nmi_n;
    logic [15:0] irq_enable;
    logic        hp_enable;
    logic        lo_gpio_sel;
    logic        mid_gpio_sel;
    logic        hi_gpio_in;
    logic        endpoint_mode;
    logic [3:0]  bus_irq_src;
    logic [15:0] irq_pending;
    logic        hp_req;
    logic [1:0]  nmi_abort;
    logic [3:0]  bus_irq_oe;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xint_pin_cond dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_irq_n     (ext_irq_n),
        .hp_irq_n      (hp_irq_n),
        .nmi_n         (nmi_n),
        .irq_enable    (irq_enable),
        .hp_enable     (hp_enable),
        .lo_gpio_sel   (lo_gpio_sel),
        .mid_gpio_sel  (mid_gpio_sel),
        .hi_gpio_in    (hi_gpio_in),
        .endpoint_mode (endpoint_mode),
        .bus_irq_src   (bus_irq_src),
        .irq_pending   (irq_pending),
        .hp_req        (hp_req),
        .nmi_abort     (nmi_abort),
        .bus_irq_oe    (bus_irq_oe)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Group rule per pin index, from R5, R6, R7.
    function automatic logic allowed(input int i, input logic ep, input logic lo,
                                     input logic mid, input logic hi);
        if (i < 4)      return !ep && !lo;
        else if (i < 8) return !mid;
        else            return hi;
    endfunction

    initial begin
        logic [15:0] en_pat [2];
        logic [15:0] exp_v;
        en_pat[0] = 16'hFFFF;
        en_pat[1] = 16'h5A3C;

        // Reset: pins asserted, everything enabled, outputs must stay 0 (R10)
        rst_n = 1'b0;
        ext_irq_n = 16'h0000; hp_irq_n = 1'b0; nmi_n = 2'b00;
        irq_enable = 16'hFFFF; hp_enable = 1'b1;
        lo_gpio_sel = 1'b0; mid_gpio_sel = 1'b0; hi_gpio_in = 1'b1;
        endpoint_mode = 1'b1; bus_irq_src = 4'hF;
        step(5);
        check("R10 pending in reset", irq_pending, 0);
        check("R10 hp in reset", hp_req, 0);
        check("R10 nmi in reset", nmi_abort, 0);
        check("R10 bus oe in reset", bus_irq_oe, 0);

        ext_irq_n = 16'hFFFF; hp_irq_n = 1'b1; nmi_n = 2'b11;
        endpoint_mode = 1'b0; bus_irq_src = 4'h0;
        step(1);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step(1);
            check("R10 no abort after reset", nmi_abort, 0);
        end

        // R1 latency and R2 level hold
        ext_irq_n[5] = 1'b0;
        step(2);
        check("R1 not before third edge", irq_pending, 0);
        step(1);
        check("R1 third edge", irq_pending, 16'h0020);
        ext_irq_n[5] = 1'b1;
        step(2);
        check("R2 held until release seen", irq_pending, 16'h0020);
        step(1);
        check("R2 cleared after release", irq_pending, 0);

        // Sweep of all mode combinations, both enable patterns, every pin
        for (int m = 0; m < 16; m++) begin
            endpoint_mode = m[0]; lo_gpio_sel = m[1];
            mid_gpio_sel  = m[2]; hi_gpio_in  = m[3];
            for (int p = 0; p < 2; p++) begin
                irq_enable = en_pat[p];
                step(1);
                for (int i = 0; i < 16; i++) begin
                    string tag;
                    tag = (i < 4) ? "R5" : ((i < 8) ? "R6" : "R7");
                    if (!en_pat[p][i]) tag = {tag, " R3"};
                    ext_irq_n = ~(16'h1 << i);
                    step(3);
                    exp_v = 16'h0;
                    exp_v[i] = en_pat[p][i] & allowed(i, m[0], m[1], m[2], m[3]);
                    check({tag, " single pin"}, irq_pending, exp_v);
                    ext_irq_n = 16'hFFFF;
                    step(3);
                    check({tag, " R2 release"}, irq_pending, 0);
                end
                ext_irq_n = 16'h0000;
                step(3);
                exp_v = 16'h0;
                for (int i = 0; i < 16; i++)
                    exp_v[i] = en_pat[p][i] & allowed(i, m[0], m[1], m[2], m[3]);
                check("R3 R5 R6 R7 all pins low", irq_pending, exp_v);
                ext_irq_n = 16'hFFFF;
                step(3);
            end
        end

        // R11 control changes take effect at the next edge
        endpoint_mode = 1'b0; lo_gpio_sel = 1'b0; mid_gpio_sel = 1'b0;
        hi_gpio_in = 1'b1; irq_enable = 16'hFFFF;
        ext_irq_n = 16'h0000;
        step(3);
        check("R11 baseline", irq_pending, 16'hFFFF);
        endpoint_mode = 1'b1;
        step(1);
        check("R11 endpoint next edge", irq_pending, 16'hFFF0);
        irq_enable = 16'h0000;
        step(1);
        check("R11 enable next edge", irq_pending, 0);
        irq_enable = 16'hFFFF; hi_gpio_in = 1'b0;
        step(1);
        check("R11 group select next edge", irq_pending, 16'h00F0);
        ext_irq_n = 16'hFFFF; endpoint_mode = 1'b0; hi_gpio_in = 1'b1;
        step(3);

        // R4 high-priority input
        hp_enable = 1'b1; hp_irq_n = 1'b0;
        step(2);
        check("R4 not before third edge", hp_req, 0);
        step(1);
        check("R4 asserted", hp_req, 1);
        hp_enable = 1'b0;
        step(1);
        check("R4 masked", hp_req, 0);
        hp_enable = 1'b1;
        step(1);
        check("R4 R11 unmasked next edge", hp_req, 1);
        hp_irq_n = 1'b1;
        step(3);
        check("R4 released", hp_req, 0);

        // R8 non-maskable edges, with every enable off
        irq_enable = 16'h0000; hp_enable = 1'b0;
        lo_gpio_sel = 1'b1; mid_gpio_sel = 1'b1; hi_gpio_in = 1'b0;
        nmi_n = 2'b10;
        step(2);
        check("R8 nmi0 not before third edge", nmi_abort, 0);
        step(1);
        check("R8 nmi0 pulse", nmi_abort, 2'b01);
        for (int k = 0; k < 5; k++) begin
            step(1);
            check("R8 held low no repeat", nmi_abort, 0);
        end
        nmi_n = 2'b11;
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R8 rising edge no pulse", nmi_abort, 0);
        end
        nmi_n = 2'b01;
        step(3);
        check("R8 nmi1 pulse", nmi_abort, 2'b10);
        step(1);
        check("R8 nmi1 single cycle", nmi_abort, 0);
        nmi_n = 2'b11;
        step(4);
        nmi_n = 2'b00;
        step(3);
        check("R8 both pulse", nmi_abort, 2'b11);
        step(1);
        check("R8 both single cycle", nmi_abort, 0);
        nmi_n = 2'b11;
        step(4);

        // R9 bus interrupt output enables
        endpoint_mode = 1'b1; bus_irq_src = 4'b1010;
        step(1);
        check("R9 oe pattern a", bus_irq_oe, 4'b1010);
        bus_irq_src = 4'b0101;
        step(1);
        check("R9 oe pattern b", bus_irq_oe, 4'b0101);
        endpoint_mode = 1'b0;
        step(1);
        check("R9 oe off outside endpoint", bus_irq_oe, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule